// File: doc/BRIEF.md
# Banked Glitch-Free Clock Gate

This block takes one input clock and hands it to two output banks. Each bank has five lines. Every line of a bank carries the same gated copy of the clock. Each bank has its own active-high enable. When the enable is high, the bank's lines follow the clock. When it is low, the lines are held low.

The enables are not applied directly. Each one is registered on the falling edge of the input clock. A bank can therefore switch on or off only while the clock is low, so every pulse it drives is a complete high phase of the input. An asynchronous, active-low reset clears both enable registers. After reset every line is low, whatever the enable inputs show. A bank starts only after the first falling edge at which its enable is seen high.

The enable inputs must meet setup and hold around the sampling falling edge. The block is meant to switch off clock branches cleanly, without runt pulses reaching downstream logic.

Top module: `bank_clkgate`

## Requirements
- R1: All five lines of a bank carry the same value at all times: either all low or all high.
- R2: While a bank is enabled, its lines are high during the input clock's high phase and low during its low phase. While a bank is disabled, its lines stay low.
- R3: While the active-low reset `rstN` is low, every output line is low, regardless of the enable inputs. Asserting reset forces the lines low at once, without waiting for a clock edge.
- R4: A change on a bank's enable input takes effect only at the next falling edge of the input clock. Until that edge, the bank keeps the mode it was in.
- R5: Every high pulse on an output line lasts exactly one high phase of the input clock and begins on a rising edge of the input clock, except when reset cuts it short.
- R6: The two banks are independent. Every combination of the two enables (both off, only bank 0, only bank 1, both on) gives each bank the behaviour set by its own enable alone.
- R7: After reset is released with an enable already high, that bank stays low until a falling edge samples the enable. Its first pulse starts on the rising edge that follows that falling edge.
- R8: No output line is ever high while the input clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be distributed |
| rstN | input | 1 | Asynchronous active-low reset; clears both enable registers |
| enBank0 | input | 1 | Active-high enable for bank 0, sampled on the falling clock edge |
| enBank1 | input | 1 | Active-high enable for bank 1, sampled on the falling clock edge |
| outBank0 | output | LINES (5) | Gated clock lines of bank 0 |
| outBank1 | output | LINES (5) | Gated clock lines of bank 1 |

## Verification
The bench steps through all sixteen ordered pairs of (previous, next) enable combinations. In each step it changes the enables just after a rising edge. This separates the old mode, still visible in the current high phase, from the new mode, which appears only after the falling edge. A pulse monitor timestamps every rising and falling edge on the lines. It rejects any pulse that is shorter or longer than one high phase, and any pulse that does not start on a rising edge of the clock. Two reset scenarios complete the run. In the first, reset is asserted in the middle of a high pulse. In the second, reset is released with both enables high. Together they separate the asynchronous clear from the requirement to wait for the first sampling falling edge.

// File: rtl/bank_clkgate_pkg.sv
package bank_clkgate_pkg;
  // number of independently gated banks
  localparam int BANKS = 2;

  // strobes handed from the control half to the datapath half
  typedef struct packed {
    logic [BANKS-1:0] passEn;   // bank may pass the clock in its next high phase
  } gateStrobe_t;
endpackage

// File: rtl/bank_clkgate_ctrl.sv
module bank_clkgate_ctrl
  import bank_clkgate_pkg::*;
#(
  parameter int NBANK = BANKS
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [NBANK-1:0] enReq,
  output gateStrobe_t      strobe
);
  logic [NBANK-1:0] enLatched;

  // capture each enable while the clock falls, so the gate only moves in the low phase
  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bankFlop
      always_ff @(negedge clkIn or negedge rstN) begin
        if (!rstN) enLatched[b] <= 1'b0;
        else       enLatched[b] <= enReq[b];
      end
    end
  endgenerate

  always_comb begin
    strobe.passEn = '0;
    strobe.passEn[NBANK-1:0] = enLatched;
  end
endmodule

// File: rtl/bank_clkgate_fanout.sv
module bank_clkgate_fanout
  import bank_clkgate_pkg::*;
#(
  parameter int LINES = 5,
  parameter int NBANK = BANKS
) (
  input  logic                        clkIn,
  input  gateStrobe_t                 strobe,
  output logic [NBANK-1:0][LINES-1:0] lineOut
);
  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bankGate
      logic gatedClk;
      assign gatedClk   = clkIn & strobe.passEn[b];
      assign lineOut[b] = {LINES{gatedClk}};
    end
  endgenerate
endmodule

// File: rtl/bank_clkgate.sv
module bank_clkgate
  import bank_clkgate_pkg::*;
#(
  parameter int LINES = 5
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             enBank0,
  input  logic             enBank1,
  output logic [LINES-1:0] outBank0,
  output logic [LINES-1:0] outBank1
);
  gateStrobe_t                 strobe;
  logic [BANKS-1:0][LINES-1:0] lineOut;
  logic [BANKS-1:0]            enReq;

  assign enReq = {enBank1, enBank0};

  bank_clkgate_ctrl #(.NBANK(BANKS)) u_ctrl (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .enReq  (enReq),
    .strobe (strobe)
  );

  bank_clkgate_fanout #(.LINES(LINES), .NBANK(BANKS)) u_fanout (
    .clkIn   (clkIn),
    .strobe  (strobe),
    .lineOut (lineOut)
  );

  assign outBank0 = lineOut[0];
  assign outBank1 = lineOut[1];
endmodule

// File: rtl/bank_clkgate_chk.sv
module bank_clkgate_chk #(
  parameter int LINES = 5
) (
  input logic             clkIn,
  input logic             rstN,
  input logic             enBank0,
  input logic             enBank1,
  input logic [LINES-1:0] outBank0,
  input logic [LINES-1:0] outBank1
);
  // R8: sampled just before a rising edge, the clock is low, so the lines must be low
  p_low_when_clk_low_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    (outBank0 == '0) && (outBank1 == '0));

  // R1: in the high phase, each bank's lines are all low or all high
  p_lines_match_r1: assert property (@(negedge clkIn) disable iff (!rstN)
    ((outBank0 == '0) || (&outBank0)) && ((outBank1 == '0) || (&outBank1)));

  // R2 / R4 / R6: the enable seen at one falling edge sets the next high phase, per bank
  p_bank0_on_r2: assert property (@(negedge clkIn) disable iff (!rstN)
    enBank0 |=> (&outBank0));
  p_bank0_off_r4: assert property (@(negedge clkIn) disable iff (!rstN)
    !enBank0 |=> (outBank0 == '0));
  p_bank1_on_r6: assert property (@(negedge clkIn) disable iff (!rstN)
    enBank1 |=> (&outBank1));
  p_bank1_off_r6: assert property (@(negedge clkIn) disable iff (!rstN)
    !enBank1 |=> (outBank1 == '0));

  // R3: while reset is held, all lines are low
  always @(posedge clkIn) begin
    if (!rstN) begin
      p_reset_low_r3: assert ((outBank0 == '0) && (outBank1 == '0));
    end
  end
endmodule

bind bank_clkgate bank_clkgate_chk #(.LINES(LINES)) u_chk (
  .clkIn    (clkIn),
  .rstN     (rstN),
  .enBank0  (enBank0),
  .enBank1  (enBank1),
  .outBank0 (outBank0),
  .outBank1 (outBank1)
);

// File: tb/bank_clkgate_bench.sv
`timescale 1ns/1ps
module bank_clkgate_bench;
  localparam int LINES = 5;
  localparam logic [LINES-1:0] ALLON = {LINES{1'b1}};

  logic clkIn = 1'b0;
  logic rstN  = 1'b1;
  logic enBank0 = 1'b0;
  logic enBank1 = 1'b0;
  logic [LINES-1:0] outBank0, outBank1;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  // 100 MHz: rising edges at 5 + 10k ns, falling edges at 10k ns
  always #5 clkIn = ~clkIn;

  bank_clkgate #(.LINES(LINES)) u_bank_clkgate (
    .clkIn(clkIn), .rstN(rstN), .enBank0(enBank0), .enBank1(enBank1),
    .outBank0(outBank0), .outBank1(outBank1)
  );

  task automatic chk(string req, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // R5: pulse monitor on every line of both banks
  for (genvar k = 0; k < 2*LINES; k++) begin : g_mon
    logic lineSig;
    time riseAt;
    assign lineSig = (k < LINES) ? outBank0[k % LINES] : outBank1[k % LINES];
    always @(posedge lineSig) begin
      riseAt = $time;
      nChecks++;
      if (($time % 10) != 5) begin
        nFails++;
        $display("FAIL R5 line %0d rise at %0t: actual phase %0t expected 5", k, $time, $time % 10);
      end
    end
    always @(negedge lineSig) begin
      if (rstN) begin
        nChecks++;
        if (($time - riseAt) != 5) begin
          nFails++;
          $display("FAIL R5 line %0d pulse width: actual %0t expected 5", k, $time - riseAt);
        end
      end
    end
  end

  function automatic logic [LINES-1:0] pat(bit on);
    return on ? ALLON : '0;
  endfunction

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R3: reset held with both enables high
    enBank0 = 1'b1; enBank1 = 1'b1;
    #1 rstN = 1'b0;
    repeat (3) @(posedge clkIn);
    #2;
    chk("R3 bank0 in reset", outBank0, '0);
    chk("R3 bank1 in reset", outBank1, '0);

    // R7: release reset in a high phase; nothing passes until a falling edge samples the enables
    #1 rstN = 1'b1;                      // posedge+3
    #1;
    chk("R7 bank0 before first sample", outBank0, '0);
    chk("R7 bank1 before first sample", outBank1, '0);
    @(posedge clkIn); #2;
    chk("R7 bank0 first pulse", outBank0, ALLON);
    chk("R7 bank1 first pulse", outBank1, ALLON);

    // R2 R4 R6 R8: every ordered pair of enable combinations
    for (int prv = 0; prv < 4; prv++) begin
      for (int nxt = 0; nxt < 4; nxt++) begin
        @(posedge clkIn); #1;
        enBank0 = prv[0]; enBank1 = prv[1];
        @(posedge clkIn); #2;
        chk("R6 bank0 old mode", outBank0, pat(prv[0]));
        chk("R6 bank1 old mode", outBank1, pat(prv[1]));
        #1;
        enBank0 = nxt[0]; enBank1 = nxt[1];
        #1;
        chk("R4 bank0 holds until fall", outBank0, pat(prv[0]));
        chk("R4 bank1 holds until fall", outBank1, pat(prv[1]));
        @(negedge clkIn); #2;
        chk("R8 bank0 low phase", outBank0, '0);
        chk("R8 bank1 low phase", outBank1, '0);
        @(posedge clkIn); #2;
        chk("R2 bank0 new mode", outBank0, pat(nxt[0]));
        chk("R2 bank1 new mode", outBank1, pat(nxt[1]));
        @(negedge clkIn); #2;
        chk("R1 bank0 lines low", outBank0, '0);
      end
    end

    // R3: asynchronous clear in the middle of a high pulse
    @(posedge clkIn); #1;
    enBank0 = 1'b1; enBank1 = 1'b1;
    @(posedge clkIn); #2;
    chk("R1 bank0 all lines high", outBank0, ALLON);
    rstN = 1'b0;
    #1;
    chk("R3 bank0 async clear", outBank0, '0);
    chk("R3 bank1 async clear", outBank1, '0);
    @(posedge clkIn); #2;
    chk("R3 bank0 held in reset", outBank0, '0);
    rstN = 1'b1;
    @(posedge clkIn); #2;
    chk("R7 bank0 after second release", outBank0, ALLON);
    chk("R7 bank1 after second release", outBank1, ALLON);

    repeat (2) @(posedge clkIn);
    finishRun();
  end
endmodule